// File: doc/BRIEF.md
# Streaming Max-Log Bit LLR Unit

This block turns a list of detector candidates into soft bit reliabilities for one received vector of a four-antenna, 256-QAM spatial-multiplexing link. Every candidate is a symbol vector with a 32-bit label and an unsigned distance metric. The candidates arrive eight at a time, and a full detection is 64 candidates delivered as eight groups. For every label bit, the unit tracks the smallest metric seen with that bit cleared and the smallest seen with it set. It then emits one signed log-likelihood ratio per bit.

Each group is reduced as it arrives. A comparison tree gives per-bit minima for the group. These are merged into a bank of running minima, so no earlier candidate is ever stored. When the group flagged as last has been absorbed, the 32 LLRs appear together with a one-cycle completion pulse.

The input stream has a valid qualifier but no ready: the unit accepts a group on every cycle that `in_valid` is high, so an upstream producer never stalls. The output is a plain registered result qualified by a pulse, with no back-pressure on either side.

Top module: `llr_maxlog_stream`

## Requirements
- R1: A group is taken on every rising edge where `in_valid` is high, with no stall. The first group of a new detection may arrive in the cycle right after the previous last group, and both detections yield correct results.
- R2: Candidate c has its label at `in_labels[c*32 +: 32]` and its metric at `in_metrics[c*16 +: 16]`. Metrics are unsigned over the full range 0 to 65535.
- R3: For each label bit and each bit value, the result uses the smallest metric among all candidates in the detection whose label has that value in that bit.
- R4: A group taken with `in_first` high discards whatever minima had been gathered before it, including a partial detection that was never finished.
- R5: Bit b's LLR is (minimum metric with bit b = 1) minus (minimum metric with bit b = 0). It appears as a 17-bit two's-complement value at `out_llr[b*17 +: 17]`, so equal minima give 0.
- R6: If no candidate in the detection has bit b set, that LLR is +65535. If none has it clear, that LLR is -65536.
- R7: `out_valid` is high for exactly the one cycle after the edge that takes a group with `in_last` high, and low at all other times.
- R8: `out_llr` changes only together with an `out_valid` pulse, and holds its value between completions.
- R9: While `rst_n` is low, `out_valid` is 0 and every LLR is 0.
- R10: Cycles with `in_valid` low have no effect, whatever `in_first`, `in_last`, labels and metrics carry then.
- R11: After a last group, the minima restart from empty. A following detection whose first group lacks `in_first` still gives results built only from its own candidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies a group of candidates in this cycle |
| in_first | input | 1 | Group opens a new detection |
| in_last | input | 1 | Group closes the current detection |
| in_labels | input | 256 | Eight 32-bit candidate labels, candidate 0 in the low bits |
| in_metrics | input | 128 | Eight 16-bit unsigned candidate metrics, candidate 0 in the low bits |
| out_valid | output | 1 | One-cycle pulse: new LLRs on `out_llr` |
| out_llr | output | 544 | Thirty-two 17-bit signed LLRs, bit 0 in the low field |

## Verification
A stale or wrong running minimum stays hidden at the ports until the detection finishes. It then surfaces in the `out_llr` fields of the affected bits on the cycle of the `out_valid` pulse, at most eight groups after the fault. The cause may be a missed merge, a tie taken the wrong way, or a reset that did not clear after a last group. A wrong presence flag shows in the same cycle as an LLR that is clamped when it should be finite, or the reverse. The model in the bench predicts the pulse and every field for every cycle. This also catches a pulse at the wrong time or an output that drifts between completions as soon as it happens.

// File: rtl/llr_pkg.sv
package llr_pkg;
  localparam int unsigned CAND_PER_GROUP = 8;
  localparam int unsigned LABEL_BITS     = 32;
  localparam int unsigned METRIC_W       = 16;
  localparam int unsigned LLR_W          = 17;

  // Bit hypothesis index used to place minima in the [2*LBITS] banks
  typedef enum logic {HYP_ZERO = 1'b0, HYP_ONE = 1'b1} hyp_e;
endpackage

// File: rtl/llr_group_min.sv
module llr_group_min
  import llr_pkg::*;
#(
  parameter int unsigned NCAND = CAND_PER_GROUP,
  parameter int unsigned LBITS = LABEL_BITS,
  parameter int unsigned MW    = METRIC_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        chk_en,
  input  logic [NCAND*LBITS-1:0]      labels,
  input  logic [NCAND*MW-1:0]         metrics,
  output logic [2*LBITS-1:0][MW-1:0]  g_min,
  output logic [2*LBITS-1:0]          g_pr
);
  localparam int unsigned NNODE  = 2*NCAND - 1;
  localparam int unsigned LEAF0  = NCAND - 1;

  // One heap-ordered comparison tree per (hypothesis, bit); left child holds
  // lower candidate indices, and ties keep the left side.
  for (genvar h = 0; h < 2; h++) begin : g_hyp
    for (genvar b = 0; b < LBITS; b++) begin : g_bit
      logic [NNODE-1:0][MW-1:0] nm;
      logic [NNODE-1:0]         np;

      for (genvar c = 0; c < NCAND; c++) begin : g_leaf
        assign np[LEAF0+c] = (labels[c*LBITS+b] == 1'(h));
        assign nm[LEAF0+c] = metrics[c*MW +: MW];

        // R3: the group minimum never exceeds any matching candidate
        p_leaf_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
          (chk_en && np[LEAF0+c]) |->
            (g_pr[h*LBITS+b] && (g_min[h*LBITS+b] <= nm[LEAF0+c])));
      end

      for (genvar i = 0; i < NCAND-1; i++) begin : g_node
        logic take_l;
        assign take_l = np[2*i+1] && (!np[2*i+2] || (nm[2*i+1] <= nm[2*i+2]));
        assign nm[i]  = take_l ? nm[2*i+1] : nm[2*i+2];
        assign np[i]  = np[2*i+1] | np[2*i+2];
      end

      assign g_min[h*LBITS+b] = np[0] ? nm[0] : '1;
      assign g_pr[h*LBITS+b]  = np[0];
    end
  end
endmodule

// File: rtl/llr_run_min.sv
module llr_run_min
  import llr_pkg::*;
#(
  parameter int unsigned LBITS = LABEL_BITS,
  parameter int unsigned MW    = METRIC_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc,
  input  logic                        first,
  input  logic                        last,
  input  logic [2*LBITS-1:0][MW-1:0]  g_min,
  input  logic [2*LBITS-1:0]          g_pr,
  output logic [2*LBITS-1:0][MW-1:0]  m_min,
  output logic [2*LBITS-1:0]          m_pr
);
  localparam int unsigned NH = 2*LBITS;

  logic [NH-1:0][MW-1:0] r_min;
  logic [NH-1:0]         r_pr;
  logic [NH-1:0]         keep_run;

  // Merge: stored minimum comes from earlier candidates and wins ties.
  always_comb begin
    for (int k = 0; k < NH; k++) begin
      keep_run[k] = !first && r_pr[k] && (!g_pr[k] || (r_min[k] <= g_min[k]));
      m_min[k]    = keep_run[k] ? r_min[k] : g_min[k];
      m_pr[k]     = g_pr[k] | (r_pr[k] & ~first);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_min <= '1;
      r_pr  <= '0;
    end else if (acc) begin
      if (last) begin
        r_min <= '1;   // R11: next detection starts empty
        r_pr  <= '0;
      end else begin
        r_min <= m_min;
        r_pr  <= m_pr;
      end
    end
  end

  for (genvar k = 0; k < NH; k++) begin : g_chk
    // R3: inside a detection a stored minimum can only shrink
    p_run_nonincr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !first && !last && r_pr[k]) |=>
        (r_pr[k] && (r_min[k] <= $past(r_min[k]))));
    // R11: closing a detection leaves every hypothesis empty
    p_clear_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && last) |=> (!r_pr[k] && (r_min[k] == '1)));
  end
endmodule

// File: rtl/llr_form.sv
module llr_form
  import llr_pkg::*;
#(
  parameter int unsigned LBITS = LABEL_BITS,
  parameter int unsigned MW    = METRIC_W,
  parameter int unsigned LW    = LLR_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [2*LBITS-1:0][MW-1:0]  m_min,
  input  logic [2*LBITS-1:0]          m_pr,
  output logic                        out_valid,
  output logic [LBITS*LW-1:0]         out_llr
);
  localparam int unsigned EW = ((MW + 2) > LW) ? (MW + 2) : LW;
  localparam logic signed [LW-1:0] LMAX = {1'b0, {(LW-1){1'b1}}};
  localparam logic signed [LW-1:0] LMIN = {1'b1, {(LW-1){1'b0}}};
  localparam logic signed [EW-1:0] EMAX = EW'((64'sd1 <<< (LW-1)) - 64'sd1);
  localparam logic signed [EW-1:0] EMIN = EW'(-(64'sd1 <<< (LW-1)));
  localparam int unsigned OFS1 = LBITS;  // HYP_ONE bank offset

  logic [LBITS*LW-1:0] llr_d;

  for (genvar b = 0; b < LBITS; b++) begin : g_bit
    logic signed [EW-1:0] diff;
    logic signed [LW-1:0] val;

    assign diff = $signed(EW'(m_min[OFS1+b])) - $signed(EW'(m_min[b]));

    always_comb begin
      if (!m_pr[OFS1+b] && !m_pr[b]) val = '0;
      else if (!m_pr[OFS1+b])        val = LMAX;
      else if (!m_pr[b])             val = LMIN;
      else if (diff > EMAX)          val = LMAX;
      else if (diff < EMIN)          val = LMIN;
      else                           val = diff[LW-1:0];
    end

    assign llr_d[b*LW +: LW] = val;

    // R5: sign follows which hypothesis had the smaller minimum
    p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && m_pr[OFS1+b] && m_pr[b] && (m_min[OFS1+b] >= m_min[b])) |=>
        !out_llr[b*LW+LW-1]);
    // R6: missing one-hypothesis drives the positive limit
    p_clamp_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !m_pr[OFS1+b] && m_pr[b]) |=> (out_llr[b*LW +: LW] == LMAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_llr   <= '0;
    end else begin
      out_valid <= load;
      if (load) out_llr <= llr_d;
    end
  end

  // R8: results only move together with the completion pulse
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_llr));
endmodule

// File: rtl/llr_maxlog_stream.sv
module llr_maxlog_stream
  import llr_pkg::*;
#(
  parameter int unsigned NCAND = CAND_PER_GROUP,
  parameter int unsigned LBITS = LABEL_BITS,
  parameter int unsigned MW    = METRIC_W,
  parameter int unsigned LW    = LLR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_first,
  input  logic                   in_last,
  input  logic [NCAND*LBITS-1:0] in_labels,
  input  logic [NCAND*MW-1:0]    in_metrics,
  output logic                   out_valid,
  output logic [LBITS*LW-1:0]    out_llr
);
  localparam int unsigned NH = 2*LBITS;

  logic [NH-1:0][MW-1:0] g_min;
  logic [NH-1:0]         g_pr;
  logic [NH-1:0][MW-1:0] m_min;
  logic [NH-1:0]         m_pr;
  logic                  done;

  assign done = in_valid & in_last;

  llr_group_min #(.NCAND(NCAND), .LBITS(LBITS), .MW(MW)) u_grp (
    .clk     (clk),
    .rst_n   (rst_n),
    .chk_en  (in_valid),
    .labels  (in_labels),
    .metrics (in_metrics),
    .g_min   (g_min),
    .g_pr    (g_pr)
  );

  llr_run_min #(.LBITS(LBITS), .MW(MW)) u_run (
    .clk   (clk),
    .rst_n (rst_n),
    .acc   (in_valid),
    .first (in_first),
    .last  (in_last),
    .g_min (g_min),
    .g_pr  (g_pr),
    .m_min (m_min),
    .m_pr  (m_pr)
  );

  llr_form #(.LBITS(LBITS), .MW(MW), .LW(LW)) u_form (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (done),
    .m_min     (m_min),
    .m_pr      (m_pr),
    .out_valid (out_valid),
    .out_llr   (out_llr)
  );

  // R7: completion pulse exactly one cycle after an accepted last group
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> out_valid);
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> !out_valid);
  // R3: every bit has at least one populated hypothesis once a group is in
  for (genvar b = 0; b < LBITS; b++) begin : g_cov
    p_hyp_cover_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (m_pr[b] | m_pr[LBITS+b]));
  end
endmodule

// File: tb/sim_llr_maxlog_stream.sv
module sim_llr_maxlog_stream;
  localparam int NC = 8, LB = 32, MW = 16, LW = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [NC*LB-1:0] in_labels  = '0;
  logic [NC*MW-1:0] in_metrics = '0;
  logic             out_valid;
  logic [LB*LW-1:0] out_llr;

  llr_maxlog_stream u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_labels(in_labels), .in_metrics(in_metrics),
    .out_valid(out_valid), .out_llr(out_llr)
  );

  int    n_tests = 0, n_fail = 0;
  string tag = "R3";
  bit    chk_en = 0, finished = 0;

  // Behavioural reference state
  int m0[LB], m1[LB];
  bit p0[LB], p1[LB];
  bit exp_valid = 0;
  int exp_llr[LB];
  logic signed [LW-1:0] got_v;

  function void model_clear();
    for (int b = 0; b < LB; b++) begin
      m0[b] = 65535; m1[b] = 65535; p0[b] = 0; p1[b] = 0;
    end
  endfunction

  task automatic chk(string r, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  initial begin
    model_clear();
    for (int b = 0; b < LB; b++) exp_llr[b] = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid = 0;
      for (int b = 0; b < LB; b++) exp_llr[b] = 0;
      model_clear();
    end else begin
      exp_valid = 0;
      if (in_valid) begin
        if (in_first) model_clear();
        for (int c = 0; c < NC; c++) begin
          for (int b = 0; b < LB; b++) begin
            if (in_labels[c*LB+b]) begin
              if (!p1[b] || int'(in_metrics[c*MW +: MW]) < m1[b]) m1[b] = int'(in_metrics[c*MW +: MW]);
              p1[b] = 1;
            end else begin
              if (!p0[b] || int'(in_metrics[c*MW +: MW]) < m0[b]) m0[b] = int'(in_metrics[c*MW +: MW]);
              p0[b] = 1;
            end
          end
        end
        if (in_last) begin
          for (int b = 0; b < LB; b++) begin
            if (!p1[b])      exp_llr[b] = 65535;
            else if (!p0[b]) exp_llr[b] = -65536;
            else             exp_llr[b] = m1[b] - m0[b];
          end
          exp_valid = 1;
          model_clear();
        end
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (chk_en && !finished) begin
      chk("R7", int'(out_valid), int'(exp_valid));
      for (int b = 0; b < LB; b++) begin
        got_v = out_llr[b*LW +: LW];
        chk(exp_valid ? tag : "R8", int'(got_v), exp_llr[b]);
      end
    end
  end

  task automatic grp(bit f, bit l, logic [LB-1:0] andm, logic [LB-1:0] orm, int mfix);
    @(negedge clk);
    in_valid = 1; in_first = f; in_last = l;
    for (int c = 0; c < NC; c++) begin
      in_labels[c*LB +: LB]  = ($urandom() & andm) | orm;
      in_metrics[c*MW +: MW] = (mfix < 0) ? MW'($urandom()) : MW'(mfix);
    end
  endtask

  task automatic idle(int n, bit junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_first = junk; in_last = junk;
      for (int c = 0; c < NC; c++) begin
        in_labels[c*LB +: LB]  = $urandom();
        in_metrics[c*MW +: MW] = junk ? MW'(0) : MW'($urandom());
      end
    end
  endtask

  task automatic blk(bit f, logic [LB-1:0] andm, logic [LB-1:0] orm, int mfix);
    for (int g = 0; g < 8; g++) grp(f && (g == 0), g == 7, andm, orm, mfix);
  endtask

  task automatic summary();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", int'(out_valid), 0);
    for (int b = 0; b < LB; b++) begin
      got_v = out_llr[b*LW +: LW];
      chk("R9", int'(got_v), 0);
    end
    rst_n = 1;
    @(negedge clk);
    chk_en = 1;

    // R3: random contiguous detection
    tag = "R3"; blk(1, '1, '0, -1); idle(2, 0);
    blk(1, '1, '0, -1); idle(1, 0);

    // R2: full-range metrics, label field positions
    tag = "R2";
    for (int g = 0; g < 7; g++) grp(g == 0, 0, '0, '0, 0);
    grp(0, 1, '0, '1, 65535);        // ones-candidates at max metric -> +65535
    idle(1, 0);
    for (int g = 0; g < 7; g++) grp(g == 0, 0, '0, '1, 0);
    grp(0, 1, '0, '0, 65535);        // zeros at max metric -> -65535
    idle(1, 0);

    // R10: idle gaps carrying junk flags and zero metrics
    tag = "R10";
    for (int g = 0; g < 8; g++) begin
      grp(g == 0, g == 7, '1, '0, -1);
      idle(2, 1);
    end
    idle(2, 1);

    // R1: back-to-back detections with no gap
    tag = "R1"; blk(1, '1, '0, -1); blk(1, '1, '0, -1); blk(1, '1, '0, -1);
    idle(1, 0);

    // R6: bit 5 never set, bit 9 never clear
    tag = "R6"; blk(1, ~(32'h1 << 5), 32'h1 << 9, -1); idle(1, 0);

    // R4: abandoned partial detection with tiny metrics, then a fresh start
    tag = "R4";
    for (int g = 0; g < 3; g++) grp(g == 0, 0, '1, '0, 0);
    blk(1, '1, '0, -1); idle(1, 0);

    // R11: detection opened without a first flag after a completed one
    tag = "R11"; blk(0, '1, '0, -1); idle(1, 0);

    // R5: equal metrics everywhere give zero where both hypotheses exist
    tag = "R5"; blk(1, '1, '0, 1234); idle(3, 0);

    summary();
  end
endmodule